// File: doc/BRIEF.md
# SDRAM Clock-Enable Low-Power State Tracker

This block sits beside a single-data-rate SDRAM command bus and follows the device's low-power condition from the pins alone. On every clock it keeps the clock-enable level seen on the previous edge. It pairs that level with the current clock-enable level, the chip-select, RAS, CAS and WE levels, and an indication that every bank is idle. From these it works out whether the device is awake (all banks idle, or some bank busy), in power-down, in self-refresh, or waking up after one of those.

A clock-enable drop from the all-banks-idle condition enters power-down or self-refresh, depending on the command presented with the drop. A rising clock enable leaves either low-power state. After a wake-up, the block holds its ready flag low for a programmable number of clocks (`EXIT_DLY`) before it reports the device awake. Command combinations that the device does not accept at these boundaries raise a single-clock illegal pulse. Decoding of ordinary bank commands, refresh scheduling and data are handled elsewhere.

All outputs are registered. Inputs are sampled on a rising clock edge, and the outputs show the result after that same edge.

Top module: `sdram_lp_tracker`

## Requirements
- R1: A synchronous active-high reset sets the state to awake-idle (code 0), sets ready to 1 and illegal to 0, and sets the stored previous clock-enable level to 1. A low clock enable on the first edge after reset therefore counts as a drop.
- R2: In an awake state (codes 0 and 1), when no clock-enable drop occurs, the next state is code 0 if all banks are idle and code 1 otherwise. Ready is 1 in both codes.
- R3: In an awake state with all banks idle, a drop (previous clock enable 1, current 0) enters power-down (code 2) when chip-select is high or when chip-select is low with RAS, CAS and WE all high (NOP). Ready then goes to 0.
- R4: In an awake state with all banks idle, a drop with chip-select, RAS and CAS low and WE high enters self-refresh (code 3).
- R5: In an awake state with all banks idle, a drop with any other command raises illegal and leaves the state at code 0.
- R6: A drop while some bank is busy never enters power-down or self-refresh. It raises illegal, and the state becomes code 1.
- R7: Power-down persists while clock enable is low. A rise (previous 0, current 1) moves to the wake-up state (code 4) whatever the command lines carry.
- R8: Self-refresh persists on every edge except a rise, whatever the command lines carry.
- R9: A rise in self-refresh with chip-select high or a NOP moves to wake-up (code 4). A rise with any other command raises illegal and keeps self-refresh.
- R10: The wake-up state lasts exactly `EXIT_DLY` clocks, with ready at 0, and ignores clock enable and the command lines. On its last edge the state becomes code 0 or code 1 according to the bank-idle input, and ready returns to 1.
- R11: The illegal output is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_i | input | 1 | Clock-enable level |
| cs_n_i | input | 1 | Chip-select, active low |
| ras_n_i | input | 1 | RAS, active low |
| cas_n_i | input | 1 | CAS, active low |
| we_n_i | input | 1 | WE, active low |
| banks_idle_i | input | 1 | High when every bank is idle |
| state_o | output | 3 | 0 awake-idle, 1 awake-busy, 2 power-down, 3 self-refresh, 4 wake-up |
| illegal_o | output | 1 | One-clock pulse on a rejected command |
| ready_o | output | 1 | High when the device is awake |

## Verification
Two functions can meet on a single edge. One is the final edge of the wake-up delay, which returns the block to an awake state. The other is a clock-enable drop carrying a self-refresh command, which would enter a low-power state if the block were already awake. The bench places that drop exactly on the last wake-up edge and expects an awake state with no entry and no illegal pulse. It also drops the bank-idle input on that same edge and expects code 1. A behavioural model in the bench judges every clock of both these directed collisions and of a long stretch of random pin activity.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

    typedef enum logic [2:0] {
        PS_IDLE   = 3'd0,
        PS_ACTIVE = 3'd1,
        PS_PDOWN  = 3'd2,
        PS_SREF   = 3'd3,
        PS_WAKE   = 3'd4
    } pwr_state_e;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_NOP   = 2'd1,
        CMD_SREF  = 2'd2,
        CMD_OTHER = 2'd3
    } cmd_class_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } cke_edge_t;

    function automatic cmd_class_e classify(input logic cs_n, input logic ras_n,
                                            input logic cas_n, input logic we_n);
        if (cs_n)
            return CMD_DESEL;
        if (ras_n && cas_n && we_n)
            return CMD_NOP;
        if (!ras_n && !cas_n && we_n)
            return CMD_SREF;
        return CMD_OTHER;
    endfunction

    function automatic logic quiet_cmd(input cmd_class_e c);
        return (c == CMD_DESEL) || (c == CMD_NOP);
    endfunction

    function automatic logic is_awake(input pwr_state_e s);
        return (s == PS_IDLE) || (s == PS_ACTIVE);
    endfunction

endpackage

// File: rtl/sdram_lp_decode.sv
module sdram_lp_decode
    import sdram_lp_pkg::*;
(
    input  logic       cke_prev_i,
    input  logic       cke_i,
    input  logic       cs_n_i,
    input  logic       ras_n_i,
    input  logic       cas_n_i,
    input  logic       we_n_i,
    output cmd_class_e cmd_o,
    output cke_edge_t  edge_o
);

    always_comb begin
        cmd_o       = classify(cs_n_i, ras_n_i, cas_n_i, we_n_i);
        edge_o.fall = cke_prev_i & ~cke_i;
        edge_o.rise = ~cke_prev_i & cke_i;
    end

endmodule

// File: rtl/sdram_lp_wake_timer.sv
module sdram_lp_wake_timer #(
    parameter int EXIT_DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic done_o
);

    localparam int CW = (EXIT_DLY < 2) ? 1 : $clog2(EXIT_DLY + 1);
    localparam logic [CW-1:0] LOAD = CW'(EXIT_DLY - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD;
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done_o = busy_q && (cnt_q == '0);

    // R10
    wake_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0 && !start_i) |=> (busy_q && cnt_q == $past(cnt_q) - CW'(1)));

    // R10
    wake_done_release_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> !busy_q);

endmodule

// File: rtl/sdram_lp_fsm.sv
module sdram_lp_fsm
    import sdram_lp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_class_e cmd_i,
    input  cke_edge_t  edge_i,
    input  logic       cke_i,
    input  logic       banks_idle_i,
    input  logic       wake_done_i,
    output pwr_state_e state_o,
    output logic       illegal_o,
    output logic       wake_start_o
);

    pwr_state_e state_q, state_d;
    logic       illegal_q, illegal_d;

    always_comb begin
        state_d      = state_q;
        illegal_d    = 1'b0;
        wake_start_o = 1'b0;
        unique case (state_q)
            PS_IDLE, PS_ACTIVE: begin
                if (edge_i.fall) begin
                    if (!banks_idle_i) begin
                        illegal_d = 1'b1;
                        state_d   = PS_ACTIVE;
                    end else if (quiet_cmd(cmd_i)) begin
                        state_d = PS_PDOWN;
                    end else if (cmd_i == CMD_SREF) begin
                        state_d = PS_SREF;
                    end else begin
                        illegal_d = 1'b1;
                        state_d   = PS_IDLE;
                    end
                end else begin
                    state_d = banks_idle_i ? PS_IDLE : PS_ACTIVE;
                end
            end
            PS_PDOWN: begin
                if (edge_i.rise) begin
                    state_d      = PS_WAKE;
                    wake_start_o = 1'b1;
                end
            end
            PS_SREF: begin
                if (edge_i.rise) begin
                    if (quiet_cmd(cmd_i)) begin
                        state_d      = PS_WAKE;
                        wake_start_o = 1'b1;
                    end else begin
                        illegal_d = 1'b1;
                    end
                end
            end
            PS_WAKE: begin
                if (wake_done_i)
                    state_d = banks_idle_i ? PS_IDLE : PS_ACTIVE;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PS_IDLE;
            illegal_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            illegal_q <= illegal_d;
        end
    end

    assign state_o   = state_q;
    assign illegal_o = illegal_q;

    // R11
    illegal_single_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_q |=> !illegal_q);

    // R6
    entry_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (is_awake(state_q) && !banks_idle_i) |=> is_awake(state_q));

    // R8
    sref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_SREF && !edge_i.rise) |=> (state_q == PS_SREF && !illegal_q));

    // R7
    pdown_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_PDOWN && edge_i.rise) |=> (state_q == PS_WAKE));

    // R7
    pdown_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_PDOWN && !cke_i) |=> (state_q == PS_PDOWN));

endmodule

// File: rtl/sdram_lp_tracker.sv
module sdram_lp_tracker
    import sdram_lp_pkg::*;
#(
    parameter int EXIT_DLY = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cke_i,
    input  logic       cs_n_i,
    input  logic       ras_n_i,
    input  logic       cas_n_i,
    input  logic       we_n_i,
    input  logic       banks_idle_i,
    output logic [2:0] state_o,
    output logic       illegal_o,
    output logic       ready_o
);

    logic       cke_prev_q;
    cmd_class_e cmd;
    cke_edge_t  cke_edge;
    logic       wake_start;
    logic       wake_done;
    pwr_state_e state;

    always_ff @(posedge clk) begin
        if (rst)
            cke_prev_q <= 1'b1;
        else
            cke_prev_q <= cke_i;
    end

    sdram_lp_decode u_decode (
        .cke_prev_i (cke_prev_q),
        .cke_i      (cke_i),
        .cs_n_i     (cs_n_i),
        .ras_n_i    (ras_n_i),
        .cas_n_i    (cas_n_i),
        .we_n_i     (we_n_i),
        .cmd_o      (cmd),
        .edge_o     (cke_edge)
    );

    sdram_lp_wake_timer #(.EXIT_DLY(EXIT_DLY)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (wake_start),
        .done_o  (wake_done)
    );

    sdram_lp_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cmd_i        (cmd),
        .edge_i       (cke_edge),
        .cke_i        (cke_i),
        .banks_idle_i (banks_idle_i),
        .wake_done_i  (wake_done),
        .state_o      (state),
        .illegal_o    (illegal_o),
        .wake_start_o (wake_start)
    );

    assign state_o = state;
    assign ready_o = is_awake(state);

    // R3
    lowpower_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd2 || state_o == 3'd3) |-> !ready_o);

    // R9
    sref_exit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3 && !cke_prev_q && cke_i && !cs_n_i && !(ras_n_i && cas_n_i && we_n_i))
        |=> (state_o == 3'd3 && illegal_o));

endmodule

// File: tb/sim_sdram_lp_tracker.sv
module sim_sdram_lp_tracker;

    localparam int DLY = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cke = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic       bidle = 1'b1;
    logic [2:0] state;
    logic       illegal, ready;

    int checks = 0;
    int failures = 0;

    sdram_lp_tracker #(.EXIT_DLY(DLY)) u0 (
        .clk(clk), .rst(rst), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
        .cas_n_i(cas_n), .we_n_i(we_n), .banks_idle_i(bidle),
        .state_o(state), .illegal_o(illegal), .ready_o(ready)
    );

    always #2 clk = ~clk;

    // Reference model
    int    m_state = 0;
    int    m_prev = 1;
    int    m_cnt = 0;
    int    m_ill = 0;
    string m_rule = "R1";
    bit    m_valid = 0;

    function automatic int cmd_kind();
        if (cs_n) return 0;
        if (ras_n && cas_n && we_n) return 1;
        if (!ras_n && !cas_n && we_n) return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        int k;
        k = cmd_kind();
        m_valid = 1;
        if (rst) begin
            m_state = 0; m_prev = 1; m_cnt = 0; m_ill = 0; m_rule = "R1";
        end else begin
            m_ill = 0;
            if (m_state <= 1) begin
                if (m_prev == 1 && cke == 0) begin
                    if (!bidle) begin m_ill = 1; m_state = 1; m_rule = "R6"; end
                    else if (k <= 1) begin m_state = 2; m_rule = "R3"; end
                    else if (k == 2) begin m_state = 3; m_rule = "R4"; end
                    else begin m_ill = 1; m_state = 0; m_rule = "R5"; end
                end else begin
                    m_state = bidle ? 0 : 1; m_rule = "R2";
                end
            end else if (m_state == 2) begin
                m_rule = "R7";
                if (m_prev == 0 && cke == 1) begin m_state = 4; m_cnt = DLY; end
            end else if (m_state == 3) begin
                if (m_prev == 0 && cke == 1) begin
                    m_rule = "R9";
                    if (k <= 1) begin m_state = 4; m_cnt = DLY; end
                    else m_ill = 1;
                end else m_rule = "R8";
            end else begin
                m_rule = "R10";
                m_cnt--;
                if (m_cnt == 0) m_state = bidle ? 0 : 1;
            end
            m_prev = cke;
        end
    end

    // Per-clock comparison, away from the active edge
    logic last_ill = 1'b0;
    always @(negedge clk) begin
        if (m_valid) begin
            checks++;
            if (state !== 3'(m_state) || illegal !== m_ill[0] || ready !== (m_state <= 1)) begin
                failures++;
                $display("FAIL %s: state=%0d ill=%0b rdy=%0b expected state=%0d ill=%0d rdy=%0d",
                         m_rule, state, illegal, ready, m_state, m_ill, (m_state <= 1));
            end
            if (illegal && last_ill) begin // R11
                checks++;
                failures++;
                $display("FAIL R11: illegal=1 on two clocks, expected 0 on second");
            end
            last_ill = illegal;
        end
    end

    // cmd: 0 deselect, 1 nop, 2 self-refresh, 3 ras low/we low, 4 cas low, 5 we low, 6 all low
    task automatic step(input logic c, input int cmd, input logic bi);
        @(negedge clk);
        cke = c; bidle = bi;
        case (cmd)
            0: {cs_n, ras_n, cas_n, we_n} = 4'b1000;
            1: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            2: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            3: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            4: {cs_n, ras_n, cas_n, we_n} = 4'b0101;
            5: {cs_n, ras_n, cas_n, we_n} = 4'b0110;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        endcase
    endtask

    task automatic expect_state(input int exp, input string tag);
        @(negedge clk);
        #1;
        checks++;
        if (state !== 3'(exp)) begin
            failures++;
            $display("FAIL %s: state=%0d expected %0d", tag, state, exp);
        end
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        checks++;
        if (state !== 3'd0 || illegal !== 1'b0 || ready !== 1'b1) begin
            failures++;
            $display("FAIL R1: state=%0d ill=%0b rdy=%0b expected 0 0 1", state, illegal, ready);
        end
        rst = 1'b0;
        // R1: first edge low counts as drop -> power-down
        cke = 1'b0; {cs_n, ras_n, cas_n, we_n} = 4'b1000;
        expect_state(2, "R1");
        step(1, 3, 1);
        for (int i = 0; i < DLY + 1; i++) step(1, 0, 1);
        // R2 busy banks
        step(1, 1, 0); step(1, 1, 0); step(1, 1, 1);
        // R3 nop drop, R7 hold and rise with other command
        step(0, 1, 1); step(0, 3, 1); step(0, 6, 1); step(1, 6, 1);
        for (int i = 0; i < DLY + 1; i++) step(1, 1, 1);
        // R3 deselect drop
        step(0, 0, 1); step(0, 0, 1); step(1, 1, 1);
        for (int i = 0; i < DLY + 1; i++) step(1, 1, 1);
        // R4 self-refresh, R8 hold with commands, R9 illegal exit then clean exit
        step(0, 2, 1); step(0, 4, 1); step(0, 6, 1); step(1, 3, 1);
        step(1, 1, 1); step(0, 1, 1); step(1, 4, 1); step(0, 0, 1); step(0, 5, 1);
        step(1, 1, 1);
        for (int i = 0; i < DLY + 1; i++) step(1, 1, 1);
        // R5 illegal drop commands
        step(0, 3, 1); step(1, 1, 1); step(0, 4, 1); step(1, 1, 1); step(0, 5, 1); step(1, 1, 1);
        // R6 drop with busy bank
        step(1, 1, 0); step(0, 2, 0); step(1, 1, 0); step(0, 1, 0); step(1, 1, 1);
        // R10 collision: drop with self-refresh command on last wake-up edge
        step(0, 1, 1); step(1, 1, 1);
        for (int i = 0; i < DLY - 1; i++) step(1, 1, 1);
        step(0, 2, 1);
        step(1, 1, 1);
        step(1, 1, 1);
        // R10 collision with busy bank on last edge
        step(0, 0, 1); step(1, 0, 1);
        for (int i = 0; i < DLY - 1; i++) step(1, 0, 1);
        step(1, 0, 0);
        expect_state(1, "R10");
        step(1, 1, 1);
        // random activity
        for (int i = 0; i < 6000; i++) begin
            step(($urandom % 10) >= 3, int'($urandom % 7), ($urandom % 5) != 0);
            if (($urandom % 997) == 0) begin
                @(negedge clk); rst = 1'b1;
                @(negedge clk); rst = 1'b0;
            end
        end
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule